// File: doc/BRIEF.md
# I2C Register Bridge with Locality Banking

This bridge sits behind a byte-level I2C target engine and in front of a 32-bit register bus that is banked by locality. The engine hands it one event at a time: start of a write, start of a read, stop, a written byte, or a request for a read byte. The bridge answers each written byte with ACK or NAK and each read request with a data byte.

The first byte of a write names a register. The bridge maps it to a bus address and adds the selected locality in the upper address bits. Bytes for the data FIFO go straight to the bus, one byte per access. Bytes for other registers are collected and written as one word at stop.

Reads of the FIFO fetch a fresh byte from the bus every time. Reads of other registers fetch a whole word once, on the first read byte, and hand it out least significant byte first. The locality select and the checksum enable are held inside the bridge. The checksum value comes in on a port.

While a bus access is pending, the bridge holds the current event. It drops `ev_ready`, so the engine can stretch the clock.

Top module: `i2c_loc_bridge`

## Requirements
- R1: An address byte (first byte after start-write) that is not one of 0x00, 0x04, 0x08, 0x14, 0x18-0x1B, 0x24, 0x30, 0x40, 0x44, 0x48, 0x4C is answered with NAK. The device-address register 0x38 is also NAKed. Nothing is stored, and a following stop makes no bus access.
- R2: After the address byte, up to 4 data bytes are ACKed into the buffer (little-endian). Any further byte to a non-FIFO register is NAKed, and the stop commits only the first 4 bytes.
- R3: Each byte written to the FIFO register (0x24) is ACKed and issued at once as a 1-byte bus write to bus address 0x024 plus the locality offset, with the byte in `bus_wdata[7:0]`. There is no limit on the byte count, and the stop adds no access.
- R4: A buffered write to a non-FIFO bus register is committed at stop as a 4-byte write, with unsent bytes zero. The commit happens only if at least one data byte followed the address. Bus bases are: 0x04 to 0x000, 0x08 to 0x008, 0x18 to 0x018, 0x30 to 0x014, 0x48 to 0xF00, 0x4C to 0xF04.
- R5: Writing value v to locality select (0x00) stores v only when v < 5. Every bus address carries the selected locality in bits [15:12]. A read of 0x00 returns the stored locality.
- R6: Writing to checksum enable (0x40) stores only bit 0 and makes no bus access. Reading 0x40 returns that bit. Reading 0x44 returns `csum_value` with no bus access.
- R7: A status write at 0x18 is a 4-byte write with data ANDed with 0x0340C26E. A status write at 0x18+k (k = 1 to 3) is a 1-byte write to bus address 0x018+k, with data ANDed with 0x0340C26E shifted right by 8k.
- R8: A status read at 0x18+k performs a 4-byte read at 0x018. It clears bits 31:26, then shifts the word right by 8k before returning bytes.
- R9: A write to interrupt enable (0x08) is ANDed with 0x80000007. Reading interrupt capability (0x14) returns 0x80000007 with no bus access.
- R10: Every FIFO read byte is a fresh 1-byte bus read. Any other register is read by one 4-byte bus read at the first read byte, and its bytes are returned LSB first. Read bytes beyond the fourth return 0x00.
- R11: Reading interface capability (0x30) returns 0x00006A12. Bit 29 of the result is set if bit 8 of the bus word read from 0x014 is set.
- R12: After reset, locality and checksum enable are 0, no bus request is pending and `ev_ready` is high. A start-write discards any partly buffered write.
- R13: While a bus request waits for `bus_ready`, its address, data, size and direction stay stable and `ev_ready` stays low. The event completes in the cycle `bus_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event presented; held until `ev_ready` |
| ev_kind | input | 3 | 0 start-write, 1 start-read, 2 stop, 3 write byte, 4 read byte |
| ev_byte | input | 8 | Written byte for kind 3 |
| ev_ready | output | 1 | Event completes in this cycle |
| ev_ack | output | 1 | ACK (1) or NAK (0) for a written byte, valid with `ev_ready` |
| ev_rbyte | output | 8 | Returned byte for kind 4, valid with `ev_ready` |
| bus_valid | output | 1 | Bus request pending |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | 16 | Bus address including locality bits |
| bus_size | output | 3 | Access size in bytes (1 or 4) |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Bus completes the request |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |
| csum_value | input | 32 | Checksum word returned by register 0x44 |

## Verification
The main function is tried with several access shapes.

Long FIFO bursts show that pass-through bytes are never counted against the buffer. Buffered writes of one, four and five data bytes separate the zero-fill, full-buffer and NAK cases. Address-only writes show that no data means no commit.

Status accesses at each byte offset tell the write mask shift apart from the read shift. Reads of more than four bytes separate cached registers from FIFO reads, which must hit the bus every time. A slow bus responder checks that events are held rather than dropped.

// File: rtl/i2c_loc_bridge.sv
module i2c_loc_bridge #(
  parameter int AW = 16,
  parameter int NUM_LOC = 5,
  parameter int LOC_SHIFT = 12,
  parameter logic [7:0] A_LOC = 8'h00,
  parameter logic [7:0] A_ACC = 8'h04,
  parameter logic [7:0] A_IEN = 8'h08,
  parameter logic [7:0] A_ICAP = 8'h14,
  parameter logic [7:0] A_STS = 8'h18,
  parameter logic [7:0] A_FIFO = 8'h24,
  parameter logic [7:0] A_IFCAP = 8'h30,
  parameter logic [7:0] A_DEV = 8'h38,
  parameter logic [7:0] A_CSEN = 8'h40,
  parameter logic [7:0] A_CSGET = 8'h44,
  parameter logic [7:0] A_ID = 8'h48,
  parameter logic [7:0] A_REV = 8'h4C,
  parameter logic [AW-1:0] B_ACC = 'h000,
  parameter logic [AW-1:0] B_IEN = 'h008,
  parameter logic [AW-1:0] B_STS = 'h018,
  parameter logic [AW-1:0] B_FIFO = 'h024,
  parameter logic [AW-1:0] B_IFCAP = 'h014,
  parameter logic [AW-1:0] B_ID = 'hF00,
  parameter logic [AW-1:0] B_REV = 'hF04,
  parameter logic [31:0] IEN_MASK = 32'h8000_0007,
  parameter logic [31:0] STS_WMASK = 32'h0340_C26E,
  parameter logic [31:0] STS_RMASK = 32'h03FF_FFFF,
  parameter logic [31:0] CAP_FIXED = 32'h0000_6A12,
  parameter int CAP_SRC = 8,
  parameter int CAP_DST = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [2:0]    ev_kind,
  input  logic [7:0]    ev_byte,
  output logic          ev_ready,
  output logic          ev_ack,
  output logic [7:0]    ev_rbyte,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_size,
  output logic [31:0]   bus_wdata,
  input  logic          bus_ready,
  input  logic [31:0]   bus_rdata,
  input  logic [31:0]   csum_value
);
  localparam int LW = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;
  localparam logic [2:0] EV_WSTART = 3'd0, EV_STOP = 3'd2, EV_WBYTE = 3'd3, EV_RBYTE = 3'd4;
  localparam logic [3:0] K_NONE = 4'd0, K_LOC = 4'd1, K_CSEN = 4'd2, K_CSGET = 4'd3, K_ICAP = 4'd4,
                         K_DEV = 4'd5, K_FIFO = 4'd6, K_STS = 4'd7, K_IEN = 4'd8, K_IFCAP = 4'd9,
                         K_PLAIN = 4'd10;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2;

  function automatic logic [3:0] kind_of(input logic [7:0] a);
    logic [7:0] d;
    d = a - A_STS;
    if (d < 8'd4) return K_STS;
    case (a)
      A_LOC:   return K_LOC;
      A_CSEN:  return K_CSEN;
      A_CSGET: return K_CSGET;
      A_ICAP:  return K_ICAP;
      A_DEV:   return K_DEV;
      A_FIFO:  return K_FIFO;
      A_IEN:   return K_IEN;
      A_IFCAP: return K_IFCAP;
      A_ACC, A_ID, A_REV: return K_PLAIN;
      default: return K_NONE;
    endcase
  endfunction

  function automatic logic [AW-1:0] base_of(input logic [7:0] a);
    case (a)
      A_ACC:   return B_ACC;
      A_IEN:   return B_IEN;
      A_FIFO:  return B_FIFO;
      A_IFCAP: return B_IFCAP;
      A_ID:    return B_ID;
      A_REV:   return B_REV;
      default: return B_STS;
    endcase
  endfunction

  logic          busy;
  logic [1:0]    op;
  logic [2:0]    off;
  logic [7:0]    areg;
  logic [31:0]   word;
  logic [LW-1:0] loc_sel;
  logic          csen;

  logic [3:0]    cur_k, in_k;
  logic [7:0]    sdiff;
  logic [1:0]    sts_o, widx;
  logic [AW-1:0] cur_addr;
  logic          first_rd, cur_busreg, need_fifo_wr, need_commit, need_rd, need_bus, fire;
  logic [31:0]   cm_data, fw;
  logic [7:0]    bufb;

  assign cur_k      = kind_of(areg);
  assign in_k       = kind_of(ev_byte);
  assign sdiff      = areg - A_STS;
  assign sts_o      = sdiff[1:0];
  assign widx       = off[1:0] - 2'd1;
  assign cur_addr   = base_of(areg) + (AW'(loc_sel) << LOC_SHIFT);
  assign first_rd   = (op == OP_SEND) && (off < 3'd2);
  assign cur_busreg = (cur_k == K_STS) || (cur_k == K_IEN) || (cur_k == K_IFCAP) || (cur_k == K_PLAIN);

  assign need_fifo_wr = (ev_kind == EV_WBYTE) && (off != 3'd0) && (off < 3'd5) && (cur_k == K_FIFO);
  assign need_commit  = (ev_kind == EV_STOP) && (op == OP_SEND) && (off > 3'd1) && cur_busreg;
  assign need_rd      = (ev_kind == EV_RBYTE) &&
                        (((op == OP_RECV) && (cur_k == K_FIFO)) ||
                         (first_rd && ((cur_k == K_FIFO) || cur_busreg)));
  assign need_bus     = need_fifo_wr || need_commit || need_rd;
  assign ev_ready     = busy ? bus_ready : !need_bus;
  assign fire         = ev_valid && ev_ready;
  assign bus_valid    = busy;

  assign cm_data = (cur_k == K_IEN) ? (word & IEN_MASK) :
                   (cur_k == K_STS) ? (word & (STS_WMASK >> {sts_o, 3'b000})) : word;

  always_comb begin
    case (cur_k)
      K_LOC:   fw = 32'(loc_sel);
      K_CSEN:  fw = {31'b0, csen};
      K_ICAP:  fw = IEN_MASK;
      K_CSGET: fw = csum_value;
      K_FIFO:  fw = {24'b0, bus_rdata[7:0]};
      K_IFCAP: fw = CAP_FIXED | (32'(bus_rdata[CAP_SRC]) << CAP_DST);
      K_STS:   fw = (bus_rdata & STS_RMASK) >> {sts_o, 3'b000};
      default: fw = bus_rdata;
    endcase
  end

  assign bufb = (off == 3'd0) ? areg : (off < 3'd5) ? word[8*widx +: 8] : 8'h00;

  always_comb begin
    ev_ack   = 1'b1;
    ev_rbyte = 8'h00;
    if (ev_kind == EV_WBYTE)
      ev_ack = (off == 3'd0) ? ((in_k != K_NONE) && (in_k != K_DEV)) : (off < 3'd5);
    if (ev_kind == EV_RBYTE) begin
      if (op == OP_RECV) ev_rbyte = (cur_k == K_FIFO) ? bus_rdata[7:0] : bufb;
      else if (first_rd) ev_rbyte = fw[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; bus_write <= 1'b0; bus_addr <= '0; bus_size <= 3'd0; bus_wdata <= 32'b0;
      op <= OP_IDLE; off <= 3'd0; areg <= 8'h00; word <= 32'b0; loc_sel <= '0; csen <= 1'b0;
    end else begin
      if (busy) begin
        if (bus_ready) busy <= 1'b0;
      end else if (ev_valid && need_bus) begin
        busy      <= 1'b1;
        bus_write <= need_fifo_wr || need_commit;
        bus_addr  <= need_commit ? cur_addr + ((cur_k == K_STS) ? AW'(sts_o) : '0) : cur_addr;
        bus_size  <= need_commit ? (((cur_k == K_STS) && (sts_o != 2'd0)) ? 3'd1 : 3'd4) :
                     (need_fifo_wr || (cur_k == K_FIFO)) ? 3'd1 : 3'd4;
        bus_wdata <= need_fifo_wr ? {24'b0, ev_byte} : need_commit ? cm_data : 32'b0;
      end
      if (fire) begin
        case (ev_kind)
          EV_WSTART: begin
            op <= OP_IDLE; off <= 3'd0; areg <= 8'h00; word <= 32'b0;
          end
          EV_STOP: begin
            if ((op == OP_SEND) && (off > 3'd1)) begin
              if ((cur_k == K_LOC) && (word[7:0] < 8'(NUM_LOC))) loc_sel <= word[LW-1:0];
              if (cur_k == K_CSEN) csen <= word[0];
            end
            op <= OP_IDLE; off <= 3'd0; areg <= 8'h00; word <= 32'b0;
          end
          EV_WBYTE: begin
            if (off == 3'd0) begin
              if (ev_ack) begin
                areg <= ev_byte; off <= 3'd1; op <= OP_SEND;
              end
            end else if (off < 3'd5) begin
              op <= OP_SEND;
              if (cur_k != K_FIFO) begin
                word[8*widx +: 8] <= ev_byte;
                off <= off + 3'd1;
              end
            end
          end
          EV_RBYTE: begin
            if (op == OP_RECV) begin
              if ((cur_k != K_FIFO) && (off < 3'd5)) off <= off + 3'd1;
            end else if (first_rd) begin
              op <= OP_RECV; word <= fw; off <= 3'd2;
            end else begin
              op <= OP_RECV;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_loc_bridge_chk.sv
module i2c_loc_bridge_chk #(
  parameter int AW = 16,
  parameter int NUM_LOC = 5,
  parameter int LOC_SHIFT = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic [2:0]    ev_kind,
  input logic          ev_ready,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [2:0]    bus_size,
  input logic [31:0]   bus_wdata,
  input logic          bus_ready
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata) &&
                                $stable(bus_size) && $stable(bus_write)); // R13
  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |-> !ev_ready); // R13
  AST_EVENT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ev_valid); // R13
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_size == 3'd1) || (bus_size == 3'd4)); // R4
  AST_LOC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> 32'(bus_addr >> LOC_SHIFT) < NUM_LOC); // R5
  AST_FIFO_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && (ev_kind == 3'd3) |-> (bus_size == 3'd1) && (bus_wdata[31:8] == 24'b0)); // R3
  AST_WORD_WRITE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && (bus_size == 3'd4) |-> ev_kind == 3'd2); // R4
endmodule

bind i2c_loc_bridge i2c_loc_bridge_chk #(.AW(AW), .NUM_LOC(NUM_LOC), .LOC_SHIFT(LOC_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_ready(ev_ready),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_wdata(bus_wdata), .bus_ready(bus_ready)
);

// File: tb/i2c_loc_bridge_bench.sv
module i2c_loc_bridge_bench;
  localparam logic [2:0] WS = 3'd0, RS = 3'd1, SP = 3'd2, WB = 3'd3, RB = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_ready, ev_ack;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'h00, ev_rbyte;
  logic bus_valid, bus_write, bus_ready = 1'b0;
  logic [15:0] bus_addr;
  logic [2:0] bus_size;
  logic [31:0] bus_wdata, bus_rdata = 32'b0, csum_value = 32'hCAFE_BABE;

  i2c_loc_bridge u_i2c_loc_bridge (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .ev_ready(ev_ready), .ev_ack(ev_ack), .ev_rbyte(ev_rbyte), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .csum_value(csum_value)
  );

  always #10 clk = ~clk;

  typedef struct {logic w; logic [15:0] a; logic [2:0] s; logic [31:0] d; string req;} bus_t;
  bus_t exp_q[$];
  int total = 0, bad = 0, lat = 0, wcnt = 0;
  logic [31:0] rd_word = 32'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_bus(logic w, logic [15:0] a, logic [2:0] s, logic [31:0] d, string req);
    bus_t e;
    e.w = w; e.a = a; e.s = s; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // bus responder and scoreboard monitor
  always @(negedge clk) begin
    if (bus_ready) bus_ready = 1'b0;
    else if (rst_n && bus_valid) begin
      if (wcnt >= lat) begin
        bus_ready = 1'b1;
        bus_rdata = rd_word;
        wcnt = 0;
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL unexpected bus access actual=%b/%h/%0d/%h expected=none",
                   bus_write, bus_addr, bus_size, bus_wdata);
        end else begin
          bus_t e;
          e = exp_q.pop_front();
          if (e.w !== bus_write || e.a !== bus_addr || e.s !== bus_size || (e.w && e.d !== bus_wdata)) begin
            bad++;
            $display("FAIL %s actual=%b/%h/%0d/%h expected=%b/%h/%0d/%h", e.req,
                     bus_write, bus_addr, bus_size, bus_wdata, e.w, e.a, e.s, e.d);
          end
        end
      end else wcnt++;
    end else wcnt = 0;
  end

  task automatic ev(input logic [2:0] k, input logic [7:0] b, output logic ack,
                    output logic [7:0] r, output int stalls);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b; stalls = 0;
    while (1) begin
      #3;
      if (ev_ready) break;
      stalls++;
      @(negedge clk);
    end
    ack = ev_ack; r = ev_rbyte;
    @(posedge clk);
    #1 ev_valid = 1'b0;
  endtask

  task automatic simple(logic [2:0] k);
    logic a; logic [7:0] r; int s;
    ev(k, 8'h00, a, r, s);
  endtask

  task automatic wb(logic [7:0] b, logic exp_ack, string req);
    logic a; logic [7:0] r; int s;
    ev(WB, b, a, r, s);
    check(req, 32'(a), 32'(exp_ack));
  endtask

  task automatic rb(logic [7:0] exp, string req);
    logic a; logic [7:0] r; int s;
    ev(RB, 8'h00, a, r, s);
    check(req, 32'(r), 32'(exp));
  endtask

  task automatic wr_reg(logic [7:0] adr, int n, logic [31:0] d, string req);
    simple(WS);
    wb(adr, 1'b1, req);
    for (int i = 0; i < n; i++) wb(d[8*i +: 8], 1'b1, req);
    simple(SP);
  endtask

  task automatic rd_reg(logic [7:0] adr, int n, logic [31:0] exp, string req);
    simple(WS);
    wb(adr, 1'b1, req);
    simple(RS);
    for (int i = 0; i < n; i++) rb(exp[8*i +: 8], req);
    simple(SP);
  endtask

  task automatic drained(string req);
    repeat (3) @(negedge clk);
    check(req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a; logic [7:0] r; int s;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    // R12 reset state
    check("R12", 32'(bus_valid), 0);
    check("R12", 32'(ev_ready), 1);
    rd_reg(8'h00, 1, 32'h0, "R12");
    rd_reg(8'h40, 1, 32'h0, "R12");

    // R1 refused addresses
    simple(WS); wb(8'h10, 1'b0, "R1"); wb(8'h38, 1'b0, "R1"); simple(SP);
    drained("R1");

    // R3 FIFO pass-through
    for (int i = 0; i < 6; i++) expect_bus(1'b1, 16'h0024, 3'd1, 32'(8'h5A + 8'(i * 17)), "R3");
    simple(WS); wb(8'h24, 1'b1, "R3");
    for (int i = 0; i < 6; i++) wb(8'h5A + 8'(i * 17), 1'b1, "R3");
    simple(SP);
    drained("R3");

    // R4 commit rules
    wr_reg(8'h04, 0, 32'h0, "R4");
    drained("R4");
    expect_bus(1'b1, 16'h0F00, 3'd4, 32'h0000_1234, "R4");
    wr_reg(8'h48, 2, 32'h0000_1234, "R4");
    drained("R4");

    // R2 buffer full
    expect_bus(1'b1, 16'h0000, 3'd4, 32'h4433_2211, "R2");
    simple(WS); wb(8'h04, 1'b1, "R2");
    wb(8'h11, 1'b1, "R2"); wb(8'h22, 1'b1, "R2"); wb(8'h33, 1'b1, "R2"); wb(8'h44, 1'b1, "R2");
    wb(8'h55, 1'b0, "R2");
    simple(SP);
    drained("R2");

    // R12 start-write discards partial write
    expect_bus(1'b1, 16'h0000, 3'd4, 32'h0000_0077, "R12");
    simple(WS); wb(8'h04, 1'b1, "R12"); wb(8'hAA, 1'b1, "R12"); wb(8'hBB, 1'b1, "R12");
    simple(WS); wb(8'h04, 1'b1, "R12"); wb(8'h77, 1'b1, "R12"); simple(SP);
    drained("R12");

    // R5 locality
    wr_reg(8'h00, 1, 32'h3, "R5");
    wr_reg(8'h00, 1, 32'h5, "R5");
    rd_reg(8'h00, 1, 32'h3, "R5");
    expect_bus(1'b1, 16'h3000, 3'd4, 32'h0000_00A5, "R5");
    wr_reg(8'h04, 1, 32'hA5, "R5");
    drained("R5");
    wr_reg(8'h00, 1, 32'h0, "R5");
    rd_reg(8'h00, 1, 32'h0, "R5");

    // R6 checksum
    wr_reg(8'h40, 1, 32'hFF, "R6");
    rd_reg(8'h40, 4, 32'h1, "R6");
    rd_reg(8'h44, 4, 32'hCAFE_BABE, "R6");
    drained("R6");

    // R7 status writes
    expect_bus(1'b1, 16'h0018, 3'd4, 32'h0340_C26E, "R7");
    wr_reg(8'h18, 4, 32'hFFFF_FFFF, "R7");
    expect_bus(1'b1, 16'h0019, 3'd1, 32'h0000_00C2, "R7");
    wr_reg(8'h19, 1, 32'hFF, "R7");
    expect_bus(1'b1, 16'h001B, 3'd1, 32'h0000_0003, "R7");
    wr_reg(8'h1B, 1, 32'hFF, "R7");
    drained("R7");

    // R8 status reads
    rd_word = 32'hFC12_3456;
    expect_bus(1'b0, 16'h0018, 3'd4, 32'h0, "R8");
    rd_reg(8'h18, 4, 32'h0012_3456, "R8");
    expect_bus(1'b0, 16'h0018, 3'd4, 32'h0, "R8");
    rd_reg(8'h19, 4, 32'h0000_1234, "R8");
    drained("R8");

    // R9 interrupt enable / capability
    expect_bus(1'b1, 16'h0008, 3'd4, 32'h8000_0007, "R9");
    wr_reg(8'h08, 4, 32'hFFFF_FFFF, "R9");
    rd_reg(8'h14, 4, 32'h8000_0007, "R9");
    drained("R9");

    // R10 cached word read, past end, FIFO fresh reads
    rd_word = 32'h1122_3344;
    expect_bus(1'b0, 16'h0F00, 3'd4, 32'h0, "R10");
    simple(WS); wb(8'h48, 1'b1, "R10"); simple(RS);
    rb(8'h44, "R10"); rb(8'h33, "R10"); rb(8'h22, "R10"); rb(8'h11, "R10"); rb(8'h00, "R10");
    simple(SP);
    drained("R10");
    for (int i = 0; i < 3; i++) expect_bus(1'b0, 16'h0024, 3'd1, 32'h0, "R10");
    simple(WS); wb(8'h24, 1'b1, "R10"); simple(RS);
    rd_word = 32'h0000_00AB; rb(8'hAB, "R10");
    rd_word = 32'h0000_00CD; rb(8'hCD, "R10");
    rd_word = 32'h0000_00EF; rb(8'hEF, "R10");
    simple(SP);
    drained("R10");

    // R11 interface capability
    rd_word = 32'h0000_0100;
    expect_bus(1'b0, 16'h0014, 3'd4, 32'h0, "R11");
    rd_reg(8'h30, 4, 32'h2000_6A12, "R11");
    rd_word = 32'hFFFF_FEFF;
    expect_bus(1'b0, 16'h0014, 3'd4, 32'h0, "R11");
    rd_reg(8'h30, 4, 32'h0000_6A12, "R11");
    drained("R11");

    // R13 stall under slow bus
    lat = 3;
    rd_word = 32'h0000_0042;
    expect_bus(1'b0, 16'h0F04, 3'd4, 32'h0, "R13");
    simple(WS); wb(8'h4C, 1'b1, "R13"); simple(RS);
    ev(RB, 8'h00, a, r, s);
    check("R13", 32'(s >= 3), 1);
    check("R13", 32'(r), 32'h42);
    simple(SP);
    drained("R13");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule